// File: doc/BRIEF.md
# Function Unit Operation Sequencer

This block is the control and operand-holding logic of one function unit in a scoreboard-style out-of-order core. It takes one issued operation and asks for each of its source operands on a separate read port. Each operand is captured as its own grant arrives. When every operand is held, the block offers the operation to an external execution pipeline. If the operation produces a result, the block waits for it, captures it and asks for the write port. Only after the write is granted does it report completion and free itself.

Each step advances when a handshake shows that a blocking condition has cleared: a read grant, pipeline acceptance, result valid or a write grant. No step waits on a fixed cycle count. The operand and result registers hold values with no architectural register number attached, so they act as anonymous rename storage. The register numbers live in the dependency logic outside this block. An operation with no result, such as a store, completes as soon as the pipeline accepts it.

Top module: `compute_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the unit to idle. After that edge, `busy`, every `rdReq` bit, `pipeValid`, `wrReq` and `done` are all 0.
- R2: Issue is taken only when `issueValid` is high while the unit is idle. `busy` is 1 from the cycle after issue through the cycle in which `done` is 1. While `busy` is 1, `issueValid` has no effect on `pipeOp` or on the operands.
- R3: The cycle after issue, `rdReq` bit i is 1 for each operand i whose `issueOpMask` bit is 1. A bit drops to 0 in the cycle after its own `rdGrant` bit is seen. Operands that are not in the mask are never requested.
- R4: Operand i is captured from `rdData[i*DATA_W +: DATA_W]` in the cycle its grant arrives. Grants for different operands may arrive in the same cycle or in any order across cycles.
- R5: `pipeValid` rises only in the cycle after the last requested operand is captured. While `pipeValid` is 1, `pipeOp` and `pipeOperands` (operand i at `[i*DATA_W +: DATA_W]`) show the held values. They stay stable until `pipeReady` is seen.
- R6: For an operation issued with `issueHasResult`=1, `done` stays 0 until the cycle after `wrReq` and `wrGrant` are both high. This holds however long the result or the grant takes.
- R7: `wrReq` is 1 from the cycle after `pipeResValid` up to and including the cycle in which `wrGrant` is seen. During that time `wrData` equals the captured `pipeResData`.
- R8: For an operation issued with `issueHasResult`=0, `done` is 1 in the cycle after `pipeReady` is seen, and `wrReq` is never raised.
- R9: `done` is high for exactly one cycle. In the next cycle `busy` is 0 and a new issue can be accepted.
- R10: An operation whose `issueOpMask` is all zeros raises no read request. `pipeValid` is 1 in the cycle right after issue.
- R11: At issue, every operand register is cleared to zero. A grant bit for an operand that is not pending (not in the mask, or already captured) leaves that operand register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issueValid | input | 1 | Issue strobe for a new operation |
| issueOp | input | OP_W | Operation code passed through to the pipeline |
| issueOpMask | input | NUM_OPS | One bit per source operand that must be read |
| issueHasResult | input | 1 | Operation produces a result that must be written back |
| busy | output | 1 | Unit holds an operation |
| rdReq | output | NUM_OPS | Read port request, one bit per operand |
| rdGrant | input | NUM_OPS | Read port grant, one bit per operand |
| rdData | input | NUM_OPS*DATA_W | Read data, operand i in slice i |
| pipeValid | output | 1 | Operation and operands offered to the pipeline |
| pipeReady | input | 1 | Pipeline accepts the offered operation |
| pipeOp | output | OP_W | Held operation code |
| pipeOperands | output | NUM_OPS*DATA_W | Held operands, operand i in slice i |
| pipeResValid | input | 1 | Pipeline result is present |
| pipeResData | input | DATA_W | Pipeline result value |
| wrReq | output | 1 | Write port request |
| wrGrant | input | 1 | Write port grant |
| wrData | output | DATA_W | Held result for the write port |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the surroundings honour the handshakes. `pipeResValid` is expected only while an accepted operation with a result is outstanding. Grants are expected to follow requests. The stimulus raises every grant, acceptance and result strobe only when the matching request or wait state is visible, and drops it after one cycle. Stray grants and repeated issue strobes are the exception: they are driven on purpose, and their lack of effect is checked through `pipeOperands` and `pipeOp`.

// File: rtl/cu_pkg.sv
package cu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_EXEC  = 3'd2,
    ST_WAITR = 3'd3,
    ST_WRITE = 3'd4,
    ST_DONE  = 3'd5
  } cuState_t;

  // strobes from control to datapath (per-operand capture is a separate vector)
  typedef struct packed {
    logic capIssue;
    logic capResult;
  } cuStrobe_t;

endpackage

// File: rtl/cu_operand_slot.sv
module cu_operand_slot #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] slotReg;

  always_ff @(posedge clk) begin
    if (rst || clear) slotReg <= '0;
    else if (load)    slotReg <= din;
  end

  assign q = slotReg;

endmodule

// File: rtl/cu_control.sv
module cu_control
  import cu_pkg::*;
#(
  parameter int unsigned NUM_OPS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issueValid,
  input  logic [NUM_OPS-1:0] issueOpMask,
  input  logic               issueHasResult,
  input  logic [NUM_OPS-1:0] rdGrant,
  input  logic               pipeReady,
  input  logic               pipeResValid,
  input  logic               wrGrant,
  output logic               busy,
  output logic [NUM_OPS-1:0] rdReq,
  output logic               pipeValid,
  output logic               wrReq,
  output logic               done,
  output cuStrobe_t          strobe,
  output logic [NUM_OPS-1:0] capOperand
);

  cuState_t           state, nextState;
  logic [NUM_OPS-1:0] pendMask;
  logic [NUM_OPS-1:0] pendNext;
  logic               hasRes;

  // operand captures only for bits still pending while reading
  always_comb begin
    capOperand = (state == ST_READ) ? (pendMask & rdGrant) : '0;
    pendNext   = pendMask & ~capOperand;
  end

  always_comb begin
    strobe.capIssue  = (state == ST_IDLE) && issueValid;
    strobe.capResult = (state == ST_WAITR) && pipeResValid;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (issueValid) nextState = (issueOpMask == '0) ? ST_EXEC : ST_READ;
      ST_READ:  if (pendNext == '0) nextState = ST_EXEC;
      ST_EXEC:  if (pipeReady) nextState = hasRes ? ST_WAITR : ST_DONE;
      ST_WAITR: if (pipeResValid) nextState = ST_WRITE;
      ST_WRITE: if (wrGrant) nextState = ST_DONE;
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pendMask <= '0;
      hasRes   <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.capIssue) begin
        pendMask <= issueOpMask;
        hasRes   <= issueHasResult;
      end else if (state == ST_READ) begin
        pendMask <= pendNext;
      end
    end
  end

  always_comb begin
    busy      = (state != ST_IDLE);
    rdReq     = (state == ST_READ) ? pendMask : '0;
    pipeValid = (state == ST_EXEC);
    wrReq     = (state == ST_WRITE);
    done      = (state == ST_DONE);
  end

endmodule

// File: rtl/cu_datapath.sv
module cu_datapath
  import cu_pkg::*;
#(
  parameter int unsigned NUM_OPS = 2,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned OP_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  cuStrobe_t                 strobe,
  input  logic [NUM_OPS-1:0]        capOperand,
  input  logic [OP_W-1:0]           issueOp,
  input  logic [NUM_OPS*DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0]         pipeResData,
  output logic [OP_W-1:0]           pipeOp,
  output logic [NUM_OPS*DATA_W-1:0] pipeOperands,
  output logic [DATA_W-1:0]         wrData
);

  logic [OP_W-1:0]   opReg;
  logic [DATA_W-1:0] resultReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      opReg     <= '0;
      resultReg <= '0;
    end else begin
      if (strobe.capIssue)  opReg     <= issueOp;
      if (strobe.capResult) resultReg <= pipeResData;
    end
  end

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_slot
    cu_operand_slot #(.DATA_W(DATA_W)) i_slot (
      .clk   (clk),
      .rst   (rst),
      .clear (strobe.capIssue),
      .load  (capOperand[i]),
      .din   (rdData[i*DATA_W +: DATA_W]),
      .q     (pipeOperands[i*DATA_W +: DATA_W])
    );
  end

  assign pipeOp = opReg;
  assign wrData = resultReg;

endmodule

// File: rtl/compute_unit.sv
module compute_unit
  import cu_pkg::*;
#(
  parameter int unsigned NUM_OPS = 2,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned OP_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      issueValid,
  input  logic [OP_W-1:0]           issueOp,
  input  logic [NUM_OPS-1:0]        issueOpMask,
  input  logic                      issueHasResult,
  output logic                      busy,
  output logic [NUM_OPS-1:0]        rdReq,
  input  logic [NUM_OPS-1:0]        rdGrant,
  input  logic [NUM_OPS*DATA_W-1:0] rdData,
  output logic                      pipeValid,
  input  logic                      pipeReady,
  output logic [OP_W-1:0]           pipeOp,
  output logic [NUM_OPS*DATA_W-1:0] pipeOperands,
  input  logic                      pipeResValid,
  input  logic [DATA_W-1:0]         pipeResData,
  output logic                      wrReq,
  input  logic                      wrGrant,
  output logic [DATA_W-1:0]         wrData,
  output logic                      done
);

  cuStrobe_t          strobe;
  logic [NUM_OPS-1:0] capOperand;

  cu_control #(.NUM_OPS(NUM_OPS)) i_control (
    .clk            (clk),
    .rst            (rst),
    .issueValid     (issueValid),
    .issueOpMask    (issueOpMask),
    .issueHasResult (issueHasResult),
    .rdGrant        (rdGrant),
    .pipeReady      (pipeReady),
    .pipeResValid   (pipeResValid),
    .wrGrant        (wrGrant),
    .busy           (busy),
    .rdReq          (rdReq),
    .pipeValid      (pipeValid),
    .wrReq          (wrReq),
    .done           (done),
    .strobe         (strobe),
    .capOperand     (capOperand)
  );

  cu_datapath #(.NUM_OPS(NUM_OPS), .DATA_W(DATA_W), .OP_W(OP_W)) i_datapath (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .capOperand   (capOperand),
    .issueOp      (issueOp),
    .rdData       (rdData),
    .pipeResData  (pipeResData),
    .pipeOp       (pipeOp),
    .pipeOperands (pipeOperands),
    .wrData       (wrData)
  );

endmodule

// File: rtl/cu_checker.sv
module cu_checker #(
  parameter int unsigned NUM_OPS = 2,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned OP_W    = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      issueValid,
  input logic                      issueHasResult,
  input logic                      busy,
  input logic [NUM_OPS-1:0]        rdReq,
  input logic [NUM_OPS-1:0]        rdGrant,
  input logic                      pipeValid,
  input logic                      pipeReady,
  input logic [OP_W-1:0]           pipeOp,
  input logic [NUM_OPS*DATA_W-1:0] pipeOperands,
  input logic                      wrReq,
  input logic                      wrGrant,
  input logic [DATA_W-1:0]         wrData,
  input logic                      done
);

  // remembers whether the operation in flight was issued with a result
  logic resFlag;
  always_ff @(posedge clk) begin
    if (rst) resFlag <= 1'b0;
    else if (issueValid && !busy) resFlag <= issueHasResult;
  end

  a_r2_busy_with_done: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  a_r2_one_phase: assert property (@(posedge clk) disable iff (rst)
    $onehot0({(rdReq != '0), pipeValid, wrReq, done}));

  a_r3_req_drops: assert property (@(posedge clk) disable iff (rst)
    ((rdReq & rdGrant) != '0) |=> ((rdReq & $past(rdReq & rdGrant)) == '0));

  a_r5_pipe_hold: assert property (@(posedge clk) disable iff (rst)
    (pipeValid && !pipeReady) |=> (pipeValid && $stable(pipeOperands) && $stable(pipeOp)));

  a_r6_done_after_write: assert property (@(posedge clk) disable iff (rst)
    (done && resFlag) |-> $past(wrReq && wrGrant));

  a_r7_wr_hold: assert property (@(posedge clk) disable iff (rst)
    (wrReq && !wrGrant) |=> (wrReq && $stable(wrData)));

  a_r8_no_write: assert property (@(posedge clk) disable iff (rst)
    (busy && !resFlag) |-> !wrReq);

  a_r8_done_after_accept: assert property (@(posedge clk) disable iff (rst)
    (done && !resFlag) |-> $past(pipeValid && pipeReady));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

endmodule

bind compute_unit cu_checker #(.NUM_OPS(NUM_OPS), .DATA_W(DATA_W), .OP_W(OP_W)) i_checker (
  .clk            (clk),
  .rst            (rst),
  .issueValid     (issueValid),
  .issueHasResult (issueHasResult),
  .busy           (busy),
  .rdReq          (rdReq),
  .rdGrant        (rdGrant),
  .pipeValid      (pipeValid),
  .pipeReady      (pipeReady),
  .pipeOp         (pipeOp),
  .pipeOperands   (pipeOperands),
  .wrReq          (wrReq),
  .wrGrant        (wrGrant),
  .wrData         (wrData),
  .done           (done)
);

// File: tb/test_compute_unit.sv
module test_compute_unit;

  localparam int unsigned NUM_OPS = 2;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned OP_W    = 4;
  localparam time         CLK_PERIOD = 10ns;

  logic                      clk = 1'b0;
  logic                      rst = 1'b1;
  logic                      issueValid = 1'b0;
  logic [OP_W-1:0]           issueOp = '0;
  logic [NUM_OPS-1:0]        issueOpMask = '0;
  logic                      issueHasResult = 1'b0;
  logic                      busy;
  logic [NUM_OPS-1:0]        rdReq;
  logic [NUM_OPS-1:0]        rdGrant = '0;
  logic [NUM_OPS*DATA_W-1:0] rdData = '0;
  logic                      pipeValid;
  logic                      pipeReady = 1'b0;
  logic [OP_W-1:0]           pipeOp;
  logic [NUM_OPS*DATA_W-1:0] pipeOperands;
  logic                      pipeResValid = 1'b0;
  logic [DATA_W-1:0]         pipeResData = '0;
  logic                      wrReq;
  logic                      wrGrant = 1'b0;
  logic [DATA_W-1:0]         wrData;
  logic                      done;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  compute_unit #(.NUM_OPS(NUM_OPS), .DATA_W(DATA_W), .OP_W(OP_W)) i_compute_unit (
    .clk(clk), .rst(rst), .issueValid(issueValid), .issueOp(issueOp),
    .issueOpMask(issueOpMask), .issueHasResult(issueHasResult), .busy(busy),
    .rdReq(rdReq), .rdGrant(rdGrant), .rdData(rdData), .pipeValid(pipeValid),
    .pipeReady(pipeReady), .pipeOp(pipeOp), .pipeOperands(pipeOperands),
    .pipeResValid(pipeResValid), .pipeResData(pipeResData), .wrReq(wrReq),
    .wrGrant(wrGrant), .wrData(wrData), .done(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic issue(input logic [OP_W-1:0] op, input logic [NUM_OPS-1:0] mask, input logic hasRes);
    issueValid = 1'b1; issueOp = op; issueOpMask = mask; issueHasResult = hasRes;
    tick();
    issueValid = 1'b0;
  endtask

  // R1: reset state, both at start and in the middle of an operation
  task automatic test_reset();
    tick(); tick();
    rst = 1'b0;
    chk("R1 busy", busy, 0); chk("R1 rdReq", rdReq, 0);
    chk("R1 pipeValid", pipeValid, 0); chk("R1 wrReq", wrReq, 0); chk("R1 done", done, 0);
    issue(4'h3, 2'b11, 1'b1);
    chk("R3 req before reset", rdReq, 2'b11);
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 mid busy", busy, 0); chk("R1 mid rdReq", rdReq, 0);
  endtask

  // full op with result: R2 R3 R4 R5 R6 R7 R9
  task automatic test_result_op(input logic [OP_W-1:0] op, input logic [DATA_W-1:0] a,
                                input logic [DATA_W-1:0] b, input bit swap,
                                input int wrWait, input logic [DATA_W-1:0] res);
    issue(op, 2'b11, 1'b1);
    chk("R2 busy after issue", busy, 1);
    chk("R3 both requested", rdReq, 2'b11);
    if (!swap) begin
      rdGrant = 2'b11; rdData = {b, a};
      tick(); rdGrant = '0;
    end else begin
      rdGrant = 2'b10; rdData = {b, 16'hDEAD};
      tick(); rdGrant = '0;
      chk("R3 op1 dropped", rdReq, 2'b01);
      chk("R5 not yet offered", pipeValid, 0);
      rdGrant = 2'b01; rdData = {16'hF00D, a};
      tick(); rdGrant = '0;
    end
    chk("R5 offered", pipeValid, 1);
    chk("R3 no requests", rdReq, 0);
    chk("R4 operands", pipeOperands, {b, a});
    chk("R5 op", pipeOp, op);
    tick();
    chk("R5 held without ready", pipeValid, 1);
    chk("R5 operands stable", pipeOperands, {b, a});
    pipeReady = 1'b1; tick(); pipeReady = 1'b0;
    chk("R6 no offer after accept", pipeValid, 0);
    chk("R6 no done while waiting", done, 0);
    chk("R7 no wrReq before result", wrReq, 0);
    tick();
    chk("R6 still waiting", done, 0);
    pipeResValid = 1'b1; pipeResData = res; tick(); pipeResValid = 1'b0; pipeResData = '0;
    chk("R7 wrReq", wrReq, 1);
    chk("R7 wrData", wrData, res);
    for (int k = 0; k < wrWait; k++) begin
      tick();
      chk("R7 wrReq held", wrReq, 1);
      chk("R6 no done before grant", done, 0);
      chk("R7 wrData held", wrData, res);
    end
    wrGrant = 1'b1; tick(); wrGrant = 1'b0;
    chk("R9 done", done, 1); chk("R2 busy at done", busy, 1); chk("R7 wrReq drop", wrReq, 0);
    tick();
    chk("R9 done pulse", done, 0); chk("R9 idle", busy, 0);
  endtask

  // R8: no result, single operand
  task automatic test_store();
    issue(4'h9, 2'b01, 1'b0);
    chk("R3 only op0", rdReq, 2'b01);
    rdGrant = 2'b01; rdData = {16'h0000, 16'h4321}; tick(); rdGrant = '0;
    chk("R4 op0", pipeOperands, {16'h0000, 16'h4321});
    pipeReady = 1'b1; tick(); pipeReady = 1'b0;
    chk("R8 done", done, 1); chk("R8 no wrReq", wrReq, 0);
    tick();
    chk("R9 idle after store", busy, 0);
  endtask

  // R10: no operands
  task automatic test_zero_ops();
    issue(4'h5, 2'b00, 1'b1);
    chk("R10 no requests", rdReq, 0);
    chk("R10 offered at once", pipeValid, 1);
    chk("R11 cleared operands", pipeOperands, 0);
    pipeReady = 1'b1; tick(); pipeReady = 1'b0;
    pipeResValid = 1'b1; pipeResData = 16'h0A0A; tick(); pipeResValid = 1'b0;
    chk("R7 wrData zero-op", wrData, 16'h0A0A);
    wrGrant = 1'b1; tick(); wrGrant = 1'b0;
    chk("R9 done zero-op", done, 1);
    tick();
  endtask

  // R2: issue while busy ignored
  task automatic test_busy_issue();
    issue(4'h7, 2'b01, 1'b0);
    rdGrant = 2'b01; rdData = {16'h0000, 16'h1111}; tick(); rdGrant = '0;
    issueValid = 1'b1; issueOp = 4'hE; issueOpMask = 2'b11; issueHasResult = 1'b1;
    tick(); tick();
    chk("R2 op kept", pipeOp, 4'h7);
    chk("R2 operands kept", pipeOperands, {16'h0000, 16'h1111});
    issueValid = 1'b0;
    pipeReady = 1'b1; tick(); pipeReady = 1'b0;
    chk("R2 done", done, 1);
    tick();
    chk("R2 idle afterwards", busy, 0);
    tick();
    chk("R2 no phantom issue", busy, 0);
  endtask

  // R11: stray grants ignored
  task automatic test_stray_grant();
    issue(4'h2, 2'b01, 1'b0);
    rdGrant = 2'b11; rdData = {16'hBEEF, 16'h1234}; tick(); rdGrant = '0;
    chk("R11 unrequested op1 zero", pipeOperands[2*DATA_W-1:DATA_W], 0);
    chk("R4 op0", pipeOperands[DATA_W-1:0], 16'h1234);
    rdGrant = 2'b01; rdData = {16'h5555, 16'h5555}; tick(); rdGrant = '0;
    chk("R11 captured op0 unchanged", pipeOperands[DATA_W-1:0], 16'h1234);
    pipeReady = 1'b1; tick(); pipeReady = 1'b0;
    chk("R8 done stray", done, 1);
    tick();
  endtask

  initial begin
    test_reset();
    test_result_op(4'h1, 16'h00AA, 16'h00BB, 1'b0, 0, 16'h1357);
    test_result_op(4'hC, 16'hCAFE, 16'h0F0F, 1'b1, 3, 16'h2468);
    test_store();
    test_zero_ops();
    test_busy_issue();
    test_stray_grant();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nTests++; nFail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule